// File: doc/BRIEF.md
# IR Run-Length Receive Sampler

This block turns a demodulated infrared input into a stream of run-length samples. It samples the input once per programmable sample period. It measures how many periods each pulse (input high) or space (input low) lasts. When a run closes, it writes one byte into a small sample RAM. Each byte holds a seven-bit count and a flag marking whether the run was a space.

The sample RAM is a ping-pong store of two halves of four slots each. The writer fills one half and then moves to the other. At that moment it raises an interrupt flag, which the host clears by writing a one. When reception is switched off while a half is partly filled, the block seals that half with a zero byte. This tells the host that no further valid data follows in that half.

Top module: `ir_runlen_rx`

## Requirements
- R1: The sample period is `period_cfg` time units when the value lies in 5..127. Values 0..4 select the default of 50 units. One time unit is `UNIT_CYC` clocks. The input is sampled once per period, counted from the clock edge at which `rx_en` is first seen high.
- R2: After enable, the block waits in idle. Samples that see a space write nothing. The first sample that sees a pulse opens a pulse run with a count of 1.
- R3: When a sample sees a level different from the open run, a byte is written one clock later. Bit 7 is 1 for a space run and 0 for a pulse run. Bits 6:0 hold the run's count. The new run starts at a count of 1.
- R4: With `ovf_en` high, a run that reaches 127 and is sampled once more at the same level writes a byte with count 127. Counting then continues in the same polarity from a count of 1.
- R5: With `ovf_en` low, the count saturates at 127 and nothing is written until the level changes.
- R6: The write address is {half, slot}: bit 2 selects the half and bits 1:0 select the slot. Slots fill in order 0..3. `wr_half` shows the half being filled and switches after slot 3 is written.
- R7: `rx_irq` rises together with the write that completes a half. It stays high until `irq_ack` is 1 at a clock edge and is low after that edge. A completion in the same cycle as an acknowledge keeps it set.
- R8: When `rx_en` is seen low, the open run is dropped. If the current half is partly filled, a 0x00 byte is written to the next slot, `rx_irq` is set and the half switches. A byte of 0x00 is never written otherwise. A later enable restarts from idle with the period counter cleared.
- R9: After reset, `wr_en`, `rx_irq` and `wr_half` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_en | input | 1 | Receive enable; low stops reception and flushes a partial half |
| ir_in | input | 1 | Demodulated IR level, 1 = pulse |
| period_cfg | input | 7 | Sample period in time units |
| ovf_en | input | 1 | Emit full-count samples on long runs |
| irq_ack | input | 1 | Write-one-to-clear for rx_irq |
| wr_en | output | 1 | Sample RAM write strobe |
| wr_addr | output | 3 | Sample RAM address {half, slot} |
| wr_data | output | 8 | Sample byte {space flag, count} |
| wr_half | output | 1 | Half currently being filled |
| rx_irq | output | 1 | Half-complete interrupt flag |

## Verification
A sample taken at clock edge T shows up as a write strobe in the cycle after T. A flush shows up in the cycle after the edge that sees `rx_en` low. `rx_irq` and the half switch share the cycle of the completing write. An acknowledge takes effect one edge later. The bench drives every level for an exact multiple of the period, starting at the edge where enable is raised. Every sampling tick therefore lands inside a known run. A monitor samples on the falling clock edge. It matches each strobe against a queue of expected bytes, addresses and interrupt states, built from the run lengths. One falling edge after its own acknowledge, it checks that the flag has cleared.

// File: rtl/ir_rl_pkg.sv
package ir_rl_pkg;
    typedef enum logic {
        RL_IDLE = 1'b0,
        RL_RUN  = 1'b1
    } rl_mode_e;
endpackage

// File: rtl/ir_rl_tick.sv
module ir_rl_tick #(
    parameter int PER_W    = 7,
    parameter int UNIT_CYC = 4,
    parameter int PER_MIN  = 5,
    parameter int PER_DEF  = 50
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_en,
    input  logic [PER_W-1:0] period_cfg,
    output logic             tick
);
    localparam int DIV_W = $clog2(((2 ** PER_W) - 1) * UNIT_CYC + 1);

    typedef struct packed {
        logic [DIV_W-1:0] div;
    } tick_st_t;

    tick_st_t st_d, st_q;
    logic [PER_W-1:0] eff_per;
    logic [DIV_W-1:0] lim;

    always_comb begin
        eff_per = (period_cfg < PER_W'(PER_MIN)) ? PER_W'(PER_DEF) : period_cfg;
        lim     = DIV_W'(eff_per) * DIV_W'(UNIT_CYC);
        tick    = rx_en && (st_q.div == lim - DIV_W'(1));
        st_d    = st_q;
        if (!rx_en || tick) begin
            st_d.div = '0;
        end else begin
            st_d.div = st_q.div + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/ir_rl_runlen.sv
module ir_rl_runlen
    import ir_rl_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           rx_en,
    input  logic           tick,
    input  logic           ir_in,
    input  logic           ovf_en,
    output logic           emit_vld,
    output logic [CNT_W:0] emit_data
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        rl_mode_e         mode;
        logic             lvl;
        logic [CNT_W-1:0] cnt;
    } rl_st_t;

    rl_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        emit_vld  = 1'b0;
        emit_data = '0;
        if (!rx_en) begin
            st_d.mode = RL_IDLE;
            st_d.lvl  = 1'b0;
            st_d.cnt  = '0;
        end else if (tick) begin
            if (st_q.mode == RL_IDLE) begin
                if (ir_in) begin
                    st_d.mode = RL_RUN;
                    st_d.lvl  = 1'b1;
                    st_d.cnt  = CNT_W'(1);
                end
            end else if (ir_in != st_q.lvl) begin
                emit_vld  = 1'b1;
                emit_data = {~st_q.lvl, st_q.cnt};
                st_d.lvl  = ir_in;
                st_d.cnt  = CNT_W'(1);
            end else if (st_q.cnt == CNT_MAX) begin
                if (ovf_en) begin
                    emit_vld  = 1'b1;
                    emit_data = {~st_q.lvl, CNT_MAX};
                    st_d.cnt  = CNT_W'(1);
                end
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{mode: RL_IDLE, lvl: 1'b0, cnt: '0};
        else        st_q <= st_d;
    end
endmodule

// File: rtl/ir_rl_writer.sv
module ir_rl_writer #(
    parameter int DATA_W = 8,
    parameter int SLOTS  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              emit_vld,
    input  logic [DATA_W-1:0] emit_data,
    input  logic              irq_ack,
    output logic              wr_en,
    output logic [$clog2(SLOTS):0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_half,
    output logic              rx_irq
);
    localparam int SLOT_W = $clog2(SLOTS);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

    typedef struct packed {
        logic [SLOT_W-1:0] slot;
        logic              half;
        logic              wen;
        logic [SLOT_W:0]   waddr;
        logic [DATA_W-1:0] wdata;
        logic              irq;
    } wr_st_t;

    wr_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.wen = 1'b0;
        st_d.irq = st_q.irq & ~irq_ack;
        if (!rx_en) begin
            if (st_q.slot != '0) begin
                st_d.wen   = 1'b1;
                st_d.waddr = {st_q.half, st_q.slot};
                st_d.wdata = '0;
                st_d.slot  = '0;
                st_d.half  = ~st_q.half;
                st_d.irq   = 1'b1;
            end
        end else if (emit_vld) begin
            st_d.wen   = 1'b1;
            st_d.waddr = {st_q.half, st_q.slot};
            st_d.wdata = emit_data;
            if (st_q.slot == LAST_SLOT) begin
                st_d.slot = '0;
                st_d.half = ~st_q.half;
                st_d.irq  = 1'b1;
            end else begin
                st_d.slot = st_q.slot + SLOT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_en   = st_q.wen;
    assign wr_addr = st_q.waddr;
    assign wr_data = st_q.wdata;
    assign wr_half = st_q.half;
    assign rx_irq  = st_q.irq;
endmodule

// File: rtl/ir_runlen_rx.sv
module ir_runlen_rx #(
    parameter int CNT_W    = 7,
    parameter int PER_W    = 7,
    parameter int UNIT_CYC = 4,
    parameter int PER_MIN  = 5,
    parameter int PER_DEF  = 50,
    parameter int SLOTS    = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      rx_en,
    input  logic                      ir_in,
    input  logic [PER_W-1:0]          period_cfg,
    input  logic                      ovf_en,
    input  logic                      irq_ack,
    output logic                      wr_en,
    output logic [$clog2(SLOTS):0]    wr_addr,
    output logic [CNT_W:0]            wr_data,
    output logic                      wr_half,
    output logic                      rx_irq
);
    localparam int DATA_W = CNT_W + 1;

    logic           tick;
    logic           emit_vld;
    logic [CNT_W:0] emit_data;

    ir_rl_tick #(
        .PER_W(PER_W), .UNIT_CYC(UNIT_CYC), .PER_MIN(PER_MIN), .PER_DEF(PER_DEF)
    ) u_tick (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .period_cfg(period_cfg), .tick(tick)
    );

    ir_rl_runlen #(.CNT_W(CNT_W)) u_runlen (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .tick(tick), .ir_in(ir_in),
        .ovf_en(ovf_en), .emit_vld(emit_vld), .emit_data(emit_data)
    );

    ir_rl_writer #(.DATA_W(DATA_W), .SLOTS(SLOTS)) u_writer (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .emit_vld(emit_vld),
        .emit_data(emit_data), .irq_ack(irq_ack), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_half(wr_half), .rx_irq(rx_irq)
    );
endmodule

// File: rtl/ir_runlen_rx_chk.sv
module ir_runlen_rx_chk #(
    parameter int CNT_W = 7
) (
    input logic           clk,
    input logic           rst_n,
    input logic           rx_en,
    input logic           irq_ack,
    input logic           wr_en,
    input logic [CNT_W:0] wr_data,
    input logic           wr_half,
    input logic           rx_irq
);
    // R8
    zero_only_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_data[CNT_W-1:0] == '0)) |-> !$past(rx_en));

    // R7
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_irq) |-> wr_en);

    // R7
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_irq && irq_ack) |=> (!rx_irq || wr_en));

    // R6
    half_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wr_half) |-> (wr_en && rx_irq));

    // R1
    min_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rx_en) |=> !wr_en);
endmodule

bind ir_runlen_rx ir_runlen_rx_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .irq_ack(irq_ack), .wr_en(wr_en),
    .wr_data(wr_data), .wr_half(wr_half), .rx_irq(rx_irq)
);

// File: tb/ir_runlen_rx_bench.sv
`timescale 1ns/1ps
module ir_runlen_rx_bench;
    localparam int U = 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_en = 1'b0;
    logic       ir_in = 1'b0;
    logic [6:0] period_cfg = 7'd5;
    logic       ovf_en = 1'b1;
    logic       irq_ack = 1'b0;
    logic       wr_en;
    logic [2:0] wr_addr;
    logic [7:0] wr_data;
    logic       wr_half;
    logic       rx_irq;

    ir_runlen_rx #(.UNIT_CYC(U)) u_ir_runlen_rx (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .ir_in(ir_in),
        .period_cfg(period_cfg), .ovf_en(ovf_en), .irq_ack(irq_ack),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_half(wr_half), .rx_irq(rx_irq)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    string tag = "R3";

    logic [7:0] exp_data [0:1023];
    logic [2:0] exp_addr [0:1023];
    bit         exp_irq  [0:1023];
    int         exp_n = 0;
    int         act_n = 0;
    logic [2:0] wp = 3'd0;

    bit   running = 1'b0;
    logic cur_lvl = 1'b0;
    int   cur_len = 0;
    bit   ack_wait = 1'b0;

    task automatic chk(input bit ok, input string t, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", t, act, exp, $time);
        end
    endtask

    function automatic int eff_lim();
        return ((period_cfg < 7'd5) ? 50 : int'(period_cfg)) * U;
    endfunction

    task automatic push(input logic [7:0] b);
        exp_data[exp_n] = b;
        exp_addr[exp_n] = wp;
        exp_irq[exp_n]  = (wp[1:0] == 2'd3);
        wp = wp + 3'd1;
        exp_n++;
    endtask

    task automatic push_flush();
        if (wp[1:0] != 2'd0) begin
            exp_data[exp_n] = 8'h00;
            exp_addr[exp_n] = wp;
            exp_irq[exp_n]  = 1'b1;
            wp = {~wp[2], 2'b00};
            exp_n++;
        end
    endtask

    task automatic close_run();
        int f;
        if (ovf_en) f = cur_len - 127 * ((cur_len - 1) / 127);
        else        f = (cur_len > 127) ? 127 : cur_len;
        push({~cur_lvl, 7'(f)});
    endtask

    // hold a level for n sample periods
    task automatic seg(input logic lvl, input int n);
        if (!running) begin
            if (lvl) begin
                running = 1'b1;
                cur_lvl = 1'b1;
                cur_len = 0;
            end
        end else if (lvl != cur_lvl) begin
            close_run();
            cur_lvl = lvl;
            cur_len = 0;
        end
        if (running) begin
            if (ovf_en) begin
                int old_c;
                int new_c;
                old_c = (cur_len == 0) ? 0 : (cur_len - 1) / 127;
                new_c = (cur_len + n - 1) / 127;
                for (int k = old_c; k < new_c; k++) push({~lvl, 7'h7f});
            end
            cur_len += n;
        end
        ir_in = lvl;
        repeat (n * eff_lim()) @(negedge clk);
    endtask

    task automatic restart(input logic [6:0] per, input logic ovf);
        ir_in   = 1'b0;
        rx_en   = 1'b0;
        running = 1'b0;
        push_flush();
        repeat (3) @(negedge clk);
        chk(act_n == exp_n, "R8", act_n, exp_n);
        period_cfg = per;
        ovf_en     = ovf;
        rx_en      = 1'b1;
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (ack_wait) begin
                irq_ack  = 1'b0;
                ack_wait = 1'b0;
                chk(rx_irq == 1'b0, "R7", int'(rx_irq), 0);
            end
            if (wr_en) begin
                if (act_n >= exp_n) begin
                    chk(1'b0, tag, int'(wr_data), -1);
                end else begin
                    chk(wr_data == exp_data[act_n], tag, int'(wr_data), int'(exp_data[act_n]));
                    chk(wr_addr == exp_addr[act_n], "R6", int'(wr_addr), int'(exp_addr[act_n]));
                    chk(wr_half == (exp_irq[act_n] ? ~exp_addr[act_n][2] : exp_addr[act_n][2]),
                        "R6", int'(wr_half), int'(exp_irq[act_n] ^ exp_addr[act_n][2]));
                    chk(rx_irq == exp_irq[act_n], "R7", int'(rx_irq), int'(exp_irq[act_n]));
                    if (rx_irq) begin
                        irq_ack  = 1'b1;
                        ack_wait = 1'b1;
                    end
                end
                act_n++;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(wr_en == 1'b0, "R9", int'(wr_en), 0);
        chk(rx_irq == 1'b0, "R9", int'(rx_irq), 0);
        chk(wr_half == 1'b0, "R9", int'(wr_half), 0);
        rst_n = 1'b1;
        @(negedge clk);
        rx_en = 1'b1;

        // R3 sweep of short pulse/space pairs
        tag = "R3";
        for (int p = 1; p <= 6; p++) begin
            for (int s = 1; s <= 6; s++) begin
                seg(1'b1, p);
                seg(1'b0, s);
            end
        end
        seg(1'b1, 1);

        // R4 long runs with full-count samples
        tag = "R4";
        seg(1'b1, 127); seg(1'b0, 128); seg(1'b1, 254); seg(1'b0, 255); seg(1'b1, 1);

        // R2 idle ignores space after restart
        tag = "R5";
        restart(7'd5, 1'b0);
        seg(1'b0, 4);
        chk(act_n == exp_n, "R2", act_n, exp_n);
        // R5 saturation without full-count samples
        seg(1'b1, 130); seg(1'b0, 300); seg(1'b1, 127); seg(1'b0, 2); seg(1'b1, 1);

        // R1 out-of-range setting selects default period
        tag = "R1";
        restart(7'd3, 1'b1);
        seg(1'b1, 2); seg(1'b0, 3); seg(1'b1, 1);
        // R1 longest legal period
        restart(7'd127, 1'b1);
        seg(1'b1, 2); seg(1'b0, 1); seg(1'b1, 1);
        // R8 flush of partial half
        tag = "R8";
        restart(7'd5, 1'b1);
        repeat (20) @(negedge clk);
        chk(act_n == exp_n, "R8", act_n, exp_n);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule